// File: doc/BRIEF.md
# Pooled Physical Register Renamer with Free List

This rename stage sits in front of a unified physical register pool in which 40 physical registers stand in for 32 architected ones. Each cycle it takes a pair of instructions, and every instruction carries up to three source specifiers and one destination specifier. All eight architected specifiers are translated to physical numbers in the same cycle through a multiported map table. The translation is combinational, so the physical numbers appear on the outputs in the same cycle as the request.

Only a load creates a new mapping. The load takes the physical register at the head of the free list, writes it into the map entry of its destination, and pushes the mapping it displaced onto a pending-release queue. A separate release strobe moves the oldest pending register back to the free list. A downstream agent raises that strobe once it has decided that the register's last use has passed. Both queues are circular buffers. Together they always hold exactly the eight registers that the map table does not name.

Top module: `preg_renamer`

## Requirements
- R1: After reset, architected register i maps to physical register i for every i in 0..31, so a non-load translates each specifier to its own number.
- R2: All eight specifiers of a pair are translated in the same cycle. Slot s field f sits at `arch_spec[(s*4+f)*5 +: 5]`, with field 3 as the destination, and its result sits at `phys_spec[(s*4+f)*6 +: 6]`.
- R3: An accepted instruction that is not a load changes no mapping and consumes no free register.
- R4: An accepted load's destination output is the free list head, and every later instruction reading that architected register receives that physical number.
- R5: A load's displaced mapping enters the tail of the pending-release queue. A release strobe on a non-empty queue moves its head to the free list tail, so released registers are handed out again in release order.
- R6: When slot 0 is an accepted load, slot 1's sources and its non-load destination that name slot 0's destination see the new physical number in the same cycle.
- R7: When both slots are accepted loads to the same destination, slot 1 receives the next free register after slot 0's, and slot 0's new register is the mapping that slot 1 displaces.
- R8: When the free list holds fewer registers than the valid loads of the pair need, `stall` is high, neither slot is granted, and no mapping changes.
- R9: A release strobe while the pending-release queue is empty has no effect.
- R10: After reset the free list hands out physical registers 32 to 39 in ascending order, with slot 0 served before slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld | input | 2 | An instruction is present in slot 0 or 1 |
| slot_is_load | input | 2 | The slot's instruction is a load and renames its destination |
| arch_spec | input | 40 | Eight 5-bit architected specifiers, slot-major; field 3 is the destination |
| release_req | input | 1 | Return the oldest pending register to the free list |
| phys_spec | output | 48 | Eight 6-bit translated physical specifiers, same order as the inputs |
| grant | output | 2 | The slot is accepted this cycle |
| stall | output | 1 | The pair is held because too few free registers are available |

## Verification
A corrupted map entry shows at the ports in the first cycle that any instruction reads that architected register. A wrong queue pointer or a lost token stays hidden until an allocation reaches the damaged slot. That can take up to eight loads, or a release followed by a full pass through the free list. For this reason the stimulus drains the free list completely, forces stalls, and recycles released registers. The outputs are compared against a reference model on every cycle, so the first divergent physical number marks the fault.

// File: rtl/preg_rename_pkg.sv
package preg_rename_pkg;
  localparam int SLOTS     = 2;
  localparam int SPECS     = 4;
  localparam int DST_FIELD = 3;
  localparam int NSPEC     = SLOTS * SPECS;

  // Number of free registers the pair asks for.
  function automatic logic [1:0] loads_needed(logic [SLOTS-1:0] vld, logic [SLOTS-1:0] ld);
    logic [SLOTS-1:0] want;
    want = vld & ld;
    return {1'b0, want[0]} + {1'b0, want[1]};
  endfunction
endpackage

// File: rtl/preg_ring.sv
module preg_ring #(
  parameter int DEPTH    = 8,
  parameter int W        = 6,
  parameter int NPUSH    = 2,
  parameter int NPOP     = 2,
  parameter int INIT_CNT = 0,
  parameter int INIT_BASE = 0,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PSW  = $clog2(NPUSH + 1),
  localparam int POW  = $clog2(NPOP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PSW-1:0]    push_n,
  input  logic [NPUSH*W-1:0] push_data,
  input  logic [POW-1:0]    pop_n,
  output logic [NPOP*W-1:0] peek,
  output logic [CW-1:0]     count
);
  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] head, tail;

  function automatic logic [PTRW-1:0] wrap_add(logic [PTRW-1:0] p, int k);
    int s;
    s = int'(p) + k;
    while (s >= DEPTH) s = s - DEPTH;
    return PTRW'(s);
  endfunction

  for (genvar k = 0; k < NPOP; k++) begin : g_peek
    assign peek[k*W +: W] = mem[wrap_add(head, k)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i < INIT_CNT) ? W'(INIT_BASE + i) : '0;
      head  <= '0;
      tail  <= wrap_add('0, INIT_CNT);
      count <= CW'(INIT_CNT);
    end else begin
      for (int k = 0; k < NPUSH; k++)
        if (k < int'(push_n)) mem[wrap_add(tail, k)] <= push_data[k*W +: W];
      head  <= wrap_add(head, int'(pop_n));
      tail  <= wrap_add(tail, int'(push_n));
      count <= count - CW'(pop_n) + CW'(push_n);
    end
  end
endmodule

// File: rtl/preg_map.sv
module preg_map #(
  parameter int N   = 32,
  parameter int AW  = 5,
  parameter int PW  = 6,
  parameter int NRD = 8,
  parameter int NWR = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NRD*AW-1:0]  rd_addr,
  output logic [NRD*PW-1:0]  rd_data,
  input  logic [NWR-1:0]     wr_en,
  input  logic [NWR*AW-1:0]  wr_addr,
  input  logic [NWR*PW-1:0]  wr_data
);
  logic [PW-1:0] tbl [N];

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r*PW +: PW] = tbl[rd_addr[r*AW +: AW]];
  end

  // Identity at reset; later write ports win on a shared address.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) tbl[i] <= PW'(i);
    end else begin
      for (int w = 0; w < NWR; w++)
        if (wr_en[w]) tbl[wr_addr[w*AW +: AW]] <= wr_data[w*PW +: PW];
    end
  end
endmodule

// File: rtl/preg_renamer.sv
module preg_renamer
  import preg_rename_pkg::*;
#(
  parameter int ARCH_N = 32,
  parameter int PHYS_N = 40,
  localparam int AW   = $clog2(ARCH_N),
  localparam int PW   = $clog2(PHYS_N),
  localparam int POOL = PHYS_N - ARCH_N,
  localparam int CW   = $clog2(POOL + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          slot_vld,
  input  logic [1:0]          slot_is_load,
  input  logic [NSPEC*AW-1:0] arch_spec,
  input  logic                release_req,
  output logic [NSPEC*PW-1:0] phys_spec,
  output logic [1:0]          grant,
  output logic                stall
);
  logic [NSPEC*PW-1:0] raw;
  logic [2*PW-1:0]     free_peek, pend_peek, pend_push_data;
  logic [CW-1:0]       free_count, pend_count;
  logic [1:0]          need, rename, alloc_cnt;
  logic                rel_fire;
  logic [AW-1:0]       dst0, dst1;
  logic [PW-1:0]       new0, new1, disp0, disp1;

  function automatic logic [AW-1:0] arch_at(int s, int f);
    return arch_spec[(s*SPECS+f)*AW +: AW];
  endfunction
  function automatic logic [PW-1:0] raw_at(logic [NSPEC*PW-1:0] v, int s, int f);
    return v[(s*SPECS+f)*PW +: PW];
  endfunction
  // Slot 1 lookup with forwarding of slot 0's new mapping (R6).
  function automatic logic [PW-1:0] fwd(logic hit_en, logic [AW-1:0] a, logic [AW-1:0] d,
                                         logic [PW-1:0] nw, logic [PW-1:0] old);
    return (hit_en && a == d) ? nw : old;
  endfunction

  preg_map #(.N(ARCH_N), .AW(AW), .PW(PW), .NRD(NSPEC), .NWR(2)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(arch_spec), .rd_data(raw),
    .wr_en(rename), .wr_addr({dst1, dst0}), .wr_data({new1, new0})
  );

  assign need     = loads_needed(slot_vld, slot_is_load);
  assign stall    = {{(CW > 2 ? CW-2 : 0){1'b0}}, need} > free_count;  // R8
  assign grant    = slot_vld & {2{~stall}};
  assign rename   = grant & slot_is_load;
  assign alloc_cnt = {1'b0, rename[0]} + {1'b0, rename[1]};
  assign rel_fire = release_req && (pend_count != '0);                  // R9

  assign dst0  = arch_at(0, DST_FIELD);
  assign dst1  = arch_at(1, DST_FIELD);
  assign new0  = free_peek[0 +: PW];
  assign new1  = rename[0] ? free_peek[PW +: PW] : free_peek[0 +: PW];  // R7
  assign disp0 = raw_at(raw, 0, DST_FIELD);
  assign disp1 = fwd(rename[0], dst1, dst0, new0, raw_at(raw, 1, DST_FIELD));

  for (genvar f = 0; f < SPECS; f++) begin : g_out
    if (f == DST_FIELD) begin : g_dst
      assign phys_spec[f*PW +: PW] = rename[0] ? new0 : disp0;
      assign phys_spec[(SPECS+f)*PW +: PW] = rename[1] ? new1 : disp1;
    end else begin : g_src
      assign phys_spec[f*PW +: PW] = raw_at(raw, 0, f);
      assign phys_spec[(SPECS+f)*PW +: PW] =
        fwd(rename[0], arch_at(1, f), dst0, new0, raw_at(raw, 1, f));
    end
  end

  assign pend_push_data = rename[0] ? {disp1, disp0} : {disp1, disp1};

  preg_ring #(.DEPTH(POOL), .W(PW), .NPUSH(2), .NPOP(2),
              .INIT_CNT(POOL), .INIT_BASE(ARCH_N)) u_free (
    .clk(clk), .rst_n(rst_n),
    .push_n(rel_fire), .push_data({pend_peek[0 +: PW], pend_peek[0 +: PW]}),
    .pop_n(alloc_cnt), .peek(free_peek), .count(free_count)
  );

  preg_ring #(.DEPTH(POOL), .W(PW), .NPUSH(2), .NPOP(2),
              .INIT_CNT(0), .INIT_BASE(0)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .push_n(alloc_cnt), .push_data(pend_push_data),
    .pop_n({1'b0, rel_fire}), .peek(pend_peek), .count(pend_count)
  );
endmodule

// File: rtl/preg_renamer_chk.sv
module preg_renamer_chk #(
  parameter int PW   = 6,
  parameter int CW   = 4,
  parameter int POOL = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic [1:0]    grant,
  input logic [1:0]    slot_is_load,
  input logic [8*PW-1:0] phys_spec,
  input logic [CW-1:0] free_count,
  input logic [CW-1:0] pend_count,
  input logic [1:0]    alloc_cnt,
  input logic          rel_fire
);
  assert_pool_conserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_count) + int'(pend_count) == POOL);

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> grant == 2'b00);

  assert_free_accounting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(free_count) == int'($past(free_count)) - int'($past(alloc_cnt)) + int'($past(rel_fire)));

  assert_distinct_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == 2'b11 && slot_is_load == 2'b11) |-> phys_spec[3*PW +: PW] != phys_spec[7*PW +: PW]);

  assert_release_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_count == '0 && alloc_cnt == 2'd0) |=> $stable(pend_count));
endmodule

bind preg_renamer preg_renamer_chk #(.PW(PW), .CW(CW), .POOL(POOL)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .grant(grant), .slot_is_load(slot_is_load),
  .phys_spec(phys_spec), .free_count(free_count), .pend_count(pend_count),
  .alloc_cnt(alloc_cnt), .rel_fire(rel_fire)
);

// File: tb/preg_renamer_bench.sv
module preg_renamer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  slot_vld = '0, slot_is_load = '0;
  logic [39:0] arch_spec = '0;
  logic        release_req = 1'b0;
  logic [47:0] phys_spec;
  logic [1:0]  grant;
  logic        stall;

  int checks = 0, fails = 0;
  int mp[32];
  int fq[$], pq[$];

  always #4 clk = ~clk;

  preg_renamer u_preg_renamer (.*);

  function automatic logic [39:0] pk(int a0, int a1, int a2, int d0, int b0, int b1, int b2, int d1);
    int v[8];
    logic [39:0] r;
    v = '{a0, a1, a2, d0, b0, b1, b2, d1};
    for (int i = 0; i < 8; i++) r[i*5 +: 5] = 5'(v[i]);
    return r;
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic step(string tag, logic [1:0] v, logic [1:0] ld, logic [39:0] sp, logic rel);
    int m[32];
    int ex[8];
    int disp[$];
    int need, used, d;
    bit st;
    @(negedge clk);
    slot_vld = v; slot_is_load = ld; arch_spec = sp; release_req = rel;
    #1;
    need = int'(v[0] & ld[0]) + int'(v[1] & ld[1]);
    st = fq.size() < need;
    m = mp; used = 0;
    for (int s = 0; s < 2; s++) begin
      for (int f = 0; f < 3; f++) ex[s*4+f] = m[sp[(s*4+f)*5 +: 5]];
      d = sp[(s*4+3)*5 +: 5];
      if (!st && v[s] && ld[s]) begin
        disp.push_back(m[d]);
        m[d] = fq[used];
        used++;
      end
      ex[s*4+3] = m[d];
    end
    chk(tag, "stall", int'(stall), int'(st));
    chk(tag, "grant", int'(grant), st ? 0 : int'(v));
    for (int i = 0; i < 8; i++)
      chk(tag, $sformatf("phys slot%0d field%0d", i/4, i%4), int'(phys_spec[i*6 +: 6]), ex[i]);
    mp = m;
    for (int u = 0; u < used; u++) void'(fq.pop_front());
    if (rel && pq.size() > 0) fq.push_back(pq.pop_front());
    foreach (disp[i]) pq.push_back(disp[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mp[i] = i;
    for (int i = 32; i < 40; i++) fq.push_back(i);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 identity after reset; R2 all eight translated together
    step("R1", 2'b11, 2'b00, pk(0, 31, 7, 12, 1, 2, 3, 30), 1'b0);
    step("R2", 2'b11, 2'b00, pk(5, 6, 8, 9, 10, 11, 13, 14), 1'b0);
    // R9 release with empty pending queue
    step("R9", 2'b00, 2'b00, pk(0, 0, 0, 0, 0, 0, 0, 0), 1'b1);
    step("R9", 2'b00, 2'b00, pk(0, 0, 0, 0, 0, 0, 0, 0), 1'b1);
    // R10/R4 first load gets 32; R6 slot 1 reads it the same cycle
    step("R6", 2'b11, 2'b01, pk(5, 1, 2, 5, 5, 3, 5, 5), 1'b0);
    // R7 both loads to the same destination
    step("R7", 2'b11, 2'b11, pk(7, 0, 0, 7, 7, 7, 1, 7), 1'b0);
    // R3 non-load keeps mappings; R4 later readers see new numbers
    step("R3", 2'b11, 2'b00, pk(7, 5, 0, 7, 5, 7, 1, 5), 1'b0);
    step("R4", 2'b01, 2'b00, pk(7, 5, 3, 0, 0, 0, 0, 0), 1'b0);
    // drain the free list: 5 left
    step("R10", 2'b11, 2'b11, pk(1, 2, 3, 10, 10, 4, 5, 11), 1'b0);
    step("R10", 2'b11, 2'b11, pk(1, 2, 3, 12, 12, 11, 5, 13), 1'b0);
    // R8 one left, pair needs two
    step("R8", 2'b11, 2'b11, pk(10, 11, 12, 20, 13, 4, 5, 21), 1'b0);
    step("R8", 2'b11, 2'b00, pk(20, 21, 10, 20, 21, 20, 12, 21), 1'b0);
    step("R10", 2'b10, 2'b10, pk(0, 0, 0, 0, 20, 10, 11, 20), 1'b0);
    step("R8", 2'b01, 2'b01, pk(20, 1, 2, 22, 0, 0, 0, 0), 1'b0);
    // R5 release three, then reuse in release order
    step("R5", 2'b00, 2'b00, pk(0, 0, 0, 0, 0, 0, 0, 0), 1'b1);
    step("R5", 2'b00, 2'b00, pk(0, 0, 0, 0, 0, 0, 0, 0), 1'b1);
    step("R5", 2'b01, 2'b01, pk(20, 5, 7, 22, 0, 0, 0, 0), 1'b1);
    step("R5", 2'b11, 2'b11, pk(22, 7, 5, 23, 23, 22, 7, 24), 1'b0);
    step("R5", 2'b11, 2'b00, pk(22, 23, 24, 5, 7, 10, 11, 12), 1'b0);

    // mixed traffic with random releases
    for (int n = 0; n < 600; n++) begin
      logic [39:0] sp;
      for (int i = 0; i < 8; i++) sp[i*5 +: 5] = 5'($urandom_range(0, 7) + ((i == 3 || i == 7) ? 0 : $urandom_range(0, 24)));
      step("R2", 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), sp, 1'($urandom_range(0, 2) != 0));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule